// File: doc/BRIEF.md
# Dual-Modulus Prescaler Counter

This block divides a fast input clock by one of two neighbouring ratios, P or P+1, chosen per output period by a modulus request. It sits in the feedback path of a frequency synthesizer: a counter controller further down the chain raises or lowers the request so that the overall division comes out as any wanted integer. A parameter picks one of three ratio pairs: 5/6, 8/9 or 10/11. A second parameter adds one divide-by-two stage after the core, which gives ratios of 2P and 2P+1 (20/21 when used with the 10/11 core).

The core is a three-bit twisted ring that normally walks six states. A shorter period is made by jumping over one or two of those states, never by loading a count. The 8/9 and 10/11 pairs add a toggle stage that marks which half of the output period the ring is in. The modulus request is five active-high lines combined by OR. It is looked at on exactly one clock edge per output period, the edge that ends the period, so the ratio can change cleanly from one output period to the next. The output is a flop and comes with its complement.

Top module: `dual_mod_prescaler`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts every state bit to one, so div_out reads 1 and div_out_n reads 0 at the next sample. The first output period after reset always has the longer length P+1, whatever the enables.
- R2: The enable lines en[4:0] are active high and combined by OR: if any one bit is 1 the next period has the short length P, and only all bits 0 gives the long length P+1.
- R3: With VARIANT=PM_DIV5_6 a long period is 3 clocks high then 3 low, and a short period is 3 high then 2 low.
- R4: With VARIANT=PM_DIV8_9 a long period is 5 clocks high then 4 low, and a short period is 4 high then 4 low.
- R5: With VARIANT=PM_DIV10_11 a long period is 6 clocks high then 5 low, and a short period is 5 high then 5 low.
- R6: The enable lines are sampled only on the rising edge at the end of the last low clock of a period. Their value at every other edge has no effect on any period length.
- R7: The ratio may change on every output period, also when the request alternates from one period to the next.
- R8: With EXT_DIV2=1 and VARIANT=PM_DIV10_11 a long period is 21 clocks (11 high, 10 low) and a short period is 20 clocks (10 high, 10 low). The request is sampled only on the edge that ends the low half.
- R9: div_out_n is the inverse of div_out at every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | NUM_EN (5) | Modulus request lines, ORed; any high selects the short ratio |
| div_out | output | 1 | Divided clock, high at the start of each period |
| div_out_n | output | 1 | Complement of div_out |

## Verification
Every result of this block shows up one edge after its cause. The state moves on each rising edge and the output is a flop, so it changes at that same edge. An enable value seen on the edge that closes a period sets the length of the period that begins at once, and a value seen on any other edge must leave no trace. The bench keeps a behavioural position-in-period model for each variant, which it advances on the rising edge from the inputs it drove half a cycle earlier. It compares the outputs on the falling edge, so each expected value lines up with the edge that produced it. It also measures the clocks between output rising edges against the model's last period length.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  typedef enum logic [1:0] {
    PM_DIV5_6   = 2'd0,
    PM_DIV8_9   = 2'd1,
    PM_DIV10_11 = 2'd2
  } pm_variant_e;

  localparam int RING_W = 3;
  typedef logic [RING_W-1:0] ring_t;

  // First state after reset and at the head of every long half.
  localparam ring_t RING_START = '1;
  // Last state of every half; the toggle stage flips when leaving it.
  localparam ring_t RING_LAST  = 3'b110;
  // State from which the all-zero state can be jumped over.
  localparam ring_t RING_DIP   = 3'b001;
endpackage

// File: rtl/pm_ring.sv
`timescale 1ns/1ps
// Three-bit twisted ring: the head bit takes the inverse of the tail bit.
// Two overrides shorten a lap: jump over 000, and enter the lap at 011.
module pm_ring
  import pm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  short_i,
  input  logic  enter4_i,
  output ring_t ring_o
);
  ring_t ring_q;
  ring_t shifted;
  ring_t ring_d;
  logic  illegal;

  always_comb begin
    shifted = {~ring_q[0], ring_q[RING_W-1:1]};
    illegal = (ring_q == 3'b010) || (ring_q == 3'b101);
    ring_d  = shifted;
    if (illegal) begin
      ring_d = RING_START;
    end else if ((ring_q == RING_DIP) && short_i) begin
      ring_d[RING_W-1] = 1'b1;
    end else if ((ring_q == RING_LAST) && enter4_i) begin
      ring_d[RING_W-1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= RING_START;
    else     ring_q <= ring_d;
  end

  assign ring_o = ring_q;

  // R3: the ring never rests in one of the two lock-up states
  p_no_lockup_r3: assert property (@(posedge clk) disable iff (rst)
    !((ring_q == 3'b010) || (ring_q == 3'b101)));

  // R3: the head state always moves on to 011
  p_head_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ring_q == RING_START) |=> (ring_q == 3'b011));
endmodule

// File: rtl/pm_ctrl.sv
`timescale 1ns/1ps
// Half tracking, modulus latch and optional divide-by-two stage.
module pm_ctrl
  import pm_pkg::*;
#(
  parameter pm_variant_e VARIANT  = PM_DIV10_11,
  parameter bit          EXT_DIV2 = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  ring_t ring_i,
  input  logic  en_any_i,
  output logic  short_o,
  output logic  enter4_o,
  output logic  div_o
);
  localparam bit HAS_TOG = (VARIANT != PM_DIV5_6);

  logic at_last;
  logic tog;
  logic term;
  logic lowmod;

  assign at_last = (ring_i == RING_LAST);

  generate
    if (HAS_TOG) begin : g_tog
      logic tog_q;
      always_ff @(posedge clk) begin
        if (rst)          tog_q <= 1'b1;
        else if (at_last) tog_q <= ~tog_q;
      end
      assign tog = tog_q;

      // R5: the half marker moves only when the ring leaves its last state
      p_tog_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !at_last |=> $stable(tog_q));
    end else begin : g_notog
      assign tog = 1'b0;
    end
  endgenerate

  // Edge that closes an output period of the core.
  assign term = at_last & ~tog;

  generate
    if (EXT_DIV2) begin : g_ext
      logic x_q;
      always_ff @(posedge clk) begin
        if (rst)       x_q <= 1'b1;
        else if (term) x_q <= ~x_q;
      end
      // The half that is about to go low is forced to the short ratio.
      assign lowmod = en_any_i | x_q;
      assign div_o  = x_q;

      // R8: the extra stage flips on every core period end
      p_x_flip_r8: assert property (@(posedge clk) disable iff (rst)
        term |=> (x_q != $past(x_q)));
    end else begin : g_core
      assign lowmod = en_any_i;
      assign div_o  = HAS_TOG ? tog : ring_i[0];
    end
  endgenerate

  generate
    if (VARIANT == PM_DIV8_9) begin : g_len89
      // Low half is always 4 long; the high half enters at 011 when short.
      assign short_o  = 1'b1;
      assign enter4_o = tog | (term & lowmod);
    end else begin : g_lenskip
      logic skip_q;
      always_ff @(posedge clk) begin
        if (rst)       skip_q <= 1'b0;
        else if (term) skip_q <= lowmod;
      end
      assign short_o  = (VARIANT == PM_DIV5_6) ? skip_q : (~tog | skip_q);
      assign enter4_o = 1'b0;

      // R6: the request is latched only at the closing edge of a period
      p_skip_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !term |=> $stable(skip_q));
    end
  endgenerate
endmodule

// File: rtl/dual_mod_prescaler.sv
`timescale 1ns/1ps
module dual_mod_prescaler
  import pm_pkg::*;
#(
  parameter pm_variant_e VARIANT  = PM_DIV10_11,
  parameter bit          EXT_DIV2 = 1'b0,
  parameter int          NUM_EN   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EN-1:0] en,
  output logic              div_out,
  output logic              div_out_n
);
  ring_t ring_w;
  logic  short_w;
  logic  enter4_w;
  logic  en_any;
  logic  div_w;

  assign en_any = |en;

  pm_ring u_ring (
    .clk      (clk),
    .rst      (rst),
    .short_i  (short_w),
    .enter4_i (enter4_w),
    .ring_o   (ring_w)
  );

  pm_ctrl #(
    .VARIANT  (VARIANT),
    .EXT_DIV2 (EXT_DIV2)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ring_i   (ring_w),
    .en_any_i (en_any),
    .short_o  (short_w),
    .enter4_o (enter4_w),
    .div_o    (div_w)
  );

  assign div_out   = div_w;
  assign div_out_n = ~div_w;

  // R1: the cycle after reset starts from the all-ones state with the output high
  p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((ring_w == RING_START) && div_out));
endmodule

// File: tb/dual_mod_prescaler_tb.sv
`timescale 1ns/1ps
module dual_mod_prescaler_tb;
  import pm_pkg::*;

  localparam int NDUT = 4;
  localparam int NEN  = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NEN-1:0]  en [NDUT];
  logic [NDUT-1:0] o;
  logic [NDUT-1:0] on;

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 1'b0;
  string tag      = "R1";

  always #10 clk = ~clk;

  dual_mod_prescaler #(.VARIANT(PM_DIV5_6), .EXT_DIV2(1'b0), .NUM_EN(NEN)) u_dut (
    .clk(clk), .rst(rst), .en(en[0]), .div_out(o[0]), .div_out_n(on[0]));
  dual_mod_prescaler #(.VARIANT(PM_DIV8_9), .EXT_DIV2(1'b0), .NUM_EN(NEN)) u_dut_b (
    .clk(clk), .rst(rst), .en(en[1]), .div_out(o[1]), .div_out_n(on[1]));
  dual_mod_prescaler #(.VARIANT(PM_DIV10_11), .EXT_DIV2(1'b0), .NUM_EN(NEN)) u_dut_c (
    .clk(clk), .rst(rst), .en(en[2]), .div_out(o[2]), .div_out_n(on[2]));
  dual_mod_prescaler #(.VARIANT(PM_DIV10_11), .EXT_DIV2(1'b1), .NUM_EN(NEN)) u_dut_d (
    .clk(clk), .rst(rst), .en(en[3]), .div_out(o[3]), .div_out_n(on[3]));

  // Period and high-run lengths taken from R3, R4, R5 and R8.
  function automatic int per_len(int k, bit lo);
    case (k)
      0:       return lo ? 5 : 6;
      1:       return lo ? 8 : 9;
      2:       return lo ? 10 : 11;
      default: return lo ? 20 : 21;
    endcase
  endfunction

  function automatic int hi_len(int k, bit lo);
    case (k)
      0:       return 3;
      1:       return lo ? 4 : 5;
      2:       return lo ? 5 : 6;
      default: return lo ? 10 : 11;
    endcase
  endfunction

  function automatic string dut_req(int k);
    case (k)
      0:       return "R3";
      1:       return "R4";
      2:       return "R5";
      default: return "R8";
    endcase
  endfunction

  // Behavioural model: position inside the current output period.
  int pos [NDUT];
  int per [NDUT];
  int hi  [NDUT];
  int prev_per [NDUT];
  int nper [NDUT];

  always @(posedge clk) begin
    for (int k = 0; k < NDUT; k++) begin
      if (rst) begin
        pos[k]  = 0;
        per[k]  = per_len(k, 1'b0);
        hi[k]   = hi_len(k, 1'b0);
        nper[k] = 0;
      end else begin
        pos[k] = pos[k] + 1;
        if (pos[k] == per[k]) begin
          prev_per[k] = per[k];
          pos[k]      = 0;
          nper[k]     = nper[k] + 1;
          per[k]      = per_len(k, |en[k]);
          hi[k]       = hi_len(k, |en[k]);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int k, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s dut%0d t=%0t actual=%0d expected=%0d", req, k, $time, act, exp);
    end
  endtask

  int since [NDUT];
  bit vld   [NDUT];
  bit last  [NDUT];

  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < NDUT; k++) begin
        bit exp_o;
        exp_o = (pos[k] < hi[k]);
        check(o[k] == exp_o, {tag, "/", dut_req(k), " output"}, k, int'(o[k]), int'(exp_o));
        check(on[k] == !o[k], "R9 complement", k, int'(on[k]), int'(!o[k]));
        if (rst) begin
          vld[k]   = 1'b0;
          since[k] = 0;
          last[k]  = 1'b1;
        end else begin
          since[k] = since[k] + 1;
          if (o[k] && !last[k]) begin
            if (vld[k])
              check(since[k] == prev_per[k], {tag, "/", dut_req(k), " rise-to-rise"},
                    k, since[k], prev_per[k]);
            vld[k]   = 1'b1;
            since[k] = 0;
          end
          last[k] = o[k];
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic set_all(logic [NEN-1:0] v);
    for (int k = 0; k < NDUT; k++) en[k] = v;
  endtask

  initial begin
    set_all('1);
    rst = 1'b1;
    repeat (3) tick();
    // R1: reset state and a long first period despite a short request
    tag = "R1";
    rst = 1'b0;
    repeat (30) tick();

    // R2: all low gives the long ratio, each single bit gives the short one
    tag = "R2";
    set_all('0);
    repeat (45) tick();
    for (int b = 0; b < NEN; b++) begin
      set_all(NEN'(1) << b);
      repeat (45) tick();
    end

    // R7: request alternates from one period to the next
    tag = "R7";
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < NDUT; k++) en[k] = nper[k][0] ? '1 : '0;
      tick();
    end

    // R6: request differs only at the sampling edge
    tag = "R6";
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < NDUT; k++) en[k] = (pos[k] == per[k] - 1) ? '0 : '1;
      tick();
    end
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < NDUT; k++) en[k] = (pos[k] == per[k] - 1) ? 5'b00100 : '0;
      tick();
    end

    // R2: random request patterns
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < NDUT; k++) en[k] = ($urandom_range(0, 1) == 1) ? NEN'($urandom) : '0;
      tick();
    end

    // R1: reset in the middle of a run
    tag = "R1";
    set_all('1);
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    repeat (45) tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule